// File: doc/BRIEF.md
# Command-Multiplexed Register Bridge

This block is the device end of a narrow bridge. A host reaches a remote register space through only two memory-mapped locations. One is a 32-bit exchange location, the other a readiness location whose bit 0 is a ready flag. Every transaction passes through the exchange location in a fixed order. The host first writes a command word, then a data word for writes only. It then reads back a status word, followed by a data word for the read-like opcodes. The ready flag paces each step.

The bridge decodes an 8-bit opcode and a 24-bit target address. It drives a request/acknowledge register port toward the register space. It also keeps two local flags: a pending-interrupt flag and a sticky overrun flag. The host can always recover from a stale response. It keeps reading the exchange location until the ready flag drops, and each read retires one pending word.

Top module: `rbb_bridge`

## Requirements
- R1: After reset the ready flag is 0, the register port request `reg_req` is low, and host reads of the exchange location return 0.
- R2: A host read at byte offset 0x060 returns the ready flag in bit 0 and zeros above it. It has no side effect.
- R3: A command written to byte offset 0x600 with opcode 0x01 or 0x02 in bits 31:24 issues one register-port read at the address in bits 23:0. After the acknowledge, the first exchange read returns the status word and the second returns the read data. The status word has the opcode in bits 31:24, the overrun flag in bit 8 and an error code in bits 7:0.
- R4: Opcode 0x10 or 0x20 waits for a second exchange write, which carries the data. It then issues one register-port write with that address and data, and presents exactly one status word.
- R5: The ready flag stays 0 from the command write until the internal access has been acknowledged.
- R6: While `reg_req` is high and `reg_ack` is low, `reg_req`, `reg_we`, `reg_addr` and `reg_wdata` hold their values.
- R7: Opcode 0x00 completes with error code 0x01, and any opcode outside the defined set completes with error code 0x02. Both present one status word and perform no register-port access.
- R8: Opcode 0x80 presents a status word, then a data word with the overrun flag in bit 1 and the pending-interrupt flag in bit 0. Opcode 0x40 clears the pending-interrupt flag and presents a status word, then a zero data word.
- R9: An exchange write made while an access is in flight or a response is pending has no effect on the transaction. It sets the overrun flag, which appears as bit 8 of the next status word presented. Reading that status word clears the flag.
- R10: Each exchange read made while ready is 1 consumes exactly one response word. Ready returns to 0 on the cycle after the last word is read.
- R11: A one-cycle pulse on `irq_set` sets the pending-interrupt flag.
- R12: Exchange reads made while no response is pending return 0 and change nothing, including reads made while the bridge waits for the data word of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | HADDR_W | Host byte offset within the bridge window |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid while host_re is high |
| irq_set | input | 1 | Pulse that raises the pending-interrupt flag |
| reg_req | output | 1 | Register-port request, held until acknowledged |
| reg_we | output | 1 | Register-port direction, 1 for write |
| reg_addr | output | RADDR_W | Register-port target address |
| reg_wdata | output | 32 | Register-port write data |
| reg_ack | input | 1 | Register-port acknowledge |
| reg_rdata | input | 32 | Register-port read data, valid with reg_ack |

## Verification
The bound checker watches several rules on every cycle. Ready must stay low while a request is outstanding. The register port must hold steady until acknowledged. Ready must drop right after the final response word. A late exchange write must set the overrun flag, and a bad opcode must complete without any request. The bench scenarios are needed for the rest. They show the actual status and data words against a shadow register file, the one-word response for writes and errors, and the local flag data of the status and interrupt-clear opcodes. They also show where the overrun bit surfaces and clears, and that a drain loop retires exactly the pending words.

// File: rtl/rbb_pkg.sv
package rbb_pkg;

  localparam logic [7:0] OPC_NULL   = 8'h00;
  localparam logic [7:0] OPC_RD     = 8'h01;
  localparam logic [7:0] OPC_SYSRD  = 8'h02;
  localparam logic [7:0] OPC_WR     = 8'h10;
  localparam logic [7:0] OPC_SYSWR  = 8'h20;
  localparam logic [7:0] OPC_IRQCLR = 8'h40;
  localparam logic [7:0] OPC_FLAGS  = 8'h80;

  localparam logic [7:0] ERC_NONE   = 8'h00;
  localparam logic [7:0] ERC_NULL   = 8'h01;
  localparam logic [7:0] ERC_UNDEF  = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WDATA  = 3'd1,
    ST_ACCESS = 3'd2,
    ST_RSTAT  = 3'd3,
    ST_RDATA  = 3'd4
  } st_e;

  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_WRITE = 2'd1,
    K_LOCAL = 2'd2,
    K_ERROR = 2'd3
  } kind_e;

endpackage

// File: rtl/rbb_cmd_decode.sv
module rbb_cmd_decode
  import rbb_pkg::*;
(
  input  logic [7:0] opcode,
  output kind_e      kind,
  output logic [7:0] err_code,
  output logic       is_flags,
  output logic       is_irqclr
);

  always_comb begin
    kind      = K_ERROR;
    err_code  = ERC_UNDEF;
    is_flags  = 1'b0;
    is_irqclr = 1'b0;
    case (opcode)
      OPC_RD, OPC_SYSRD: begin
        kind     = K_READ;
        err_code = ERC_NONE;
      end
      OPC_WR, OPC_SYSWR: begin
        kind     = K_WRITE;
        err_code = ERC_NONE;
      end
      OPC_FLAGS: begin
        kind     = K_LOCAL;
        err_code = ERC_NONE;
        is_flags = 1'b1;
      end
      OPC_IRQCLR: begin
        kind      = K_LOCAL;
        err_code  = ERC_NONE;
        is_irqclr = 1'b1;
      end
      OPC_NULL: begin
        kind     = K_ERROR;
        err_code = ERC_NULL;
      end
      default: begin
        kind     = K_ERROR;
        err_code = ERC_UNDEF;
      end
    endcase
  end

endmodule

// File: rtl/rbb_reg_port.sv
module rbb_reg_port #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  output logic          done,
  output logic          reg_req,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic          reg_ack
);

  logic          req_q, req_n;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_comb begin
    req_n = req_q;
    if (start)
      req_n = 1'b1;
    else if (req_q && reg_ack)
      req_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      we_q    <= start_we;
      addr_q  <= start_addr;
      wdata_q <= start_wdata;
    end
  end

  assign done      = req_q & reg_ack;
  assign reg_req   = req_q;
  assign reg_we    = we_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;

endmodule

// File: rtl/rbb_resp_mux.sv
module rbb_resp_mux #(
  parameter int DW = 32
) (
  input  logic          sel_xfer,
  input  logic          sel_ready,
  input  logic          ready,
  input  logic          show_status,
  input  logic          show_data,
  input  logic [DW-1:0] status_word,
  input  logic [DW-1:0] data_word,
  output logic [DW-1:0] rdata
);

  always_comb begin
    rdata = '0;
    if (sel_ready) begin
      rdata[0] = ready;
    end else if (sel_xfer) begin
      if (show_status)
        rdata = status_word;
      else if (show_data)
        rdata = data_word;
    end
  end

endmodule

// File: rtl/rbb_bridge.sv
module rbb_bridge
  import rbb_pkg::*;
#(
  parameter int                  HADDR_W     = 12,
  parameter logic [HADDR_W-1:0]  XFER_OFS    = 12'h600,
  parameter logic [HADDR_W-1:0]  READY_OFS   = 12'h060,
  parameter int                  RADDR_W     = 24,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic               host_we,
  input  logic               host_re,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic               irq_set,
  output logic               reg_req,
  output logic               reg_we,
  output logic [RADDR_W-1:0] reg_addr,
  output logic [31:0]        reg_wdata,
  input  logic               reg_ack,
  input  logic [31:0]        reg_rdata
);

  localparam int DW    = 32;
  localparam int OP_W  = DW - RADDR_W;
  localparam int ERR_W = 8;
  localparam int PAD_W = DW - OP_W - 1 - ERR_W;

  // reset: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_s_n = rsync_q[SYNC_STAGES-1];

  // host decode
  logic xfer_wr, xfer_rd, ready_rd;
  assign xfer_wr  = host_we && (host_addr == XFER_OFS);
  assign xfer_rd  = host_re && !host_we && (host_addr == XFER_OFS);
  assign ready_rd = host_re && !host_we && (host_addr == READY_OFS);

  logic [OP_W-1:0]    cmd_op;
  logic [RADDR_W-1:0] cmd_addr;
  assign cmd_op   = host_wdata[DW-1:RADDR_W];
  assign cmd_addr = host_wdata[RADDR_W-1:0];

  kind_e            dec_kind;
  logic [ERR_W-1:0] dec_err;
  logic             dec_flags, dec_irqclr;

  rbb_cmd_decode u_dec (
    .opcode   (cmd_op),
    .kind     (dec_kind),
    .err_code (dec_err),
    .is_flags (dec_flags),
    .is_irqclr(dec_irqclr)
  );

  // transaction state
  st_e                state_q, st_n;
  logic [OP_W-1:0]    op_q, op_n;
  logic [RADDR_W-1:0] addr_q, addr_n;
  logic [DW-1:0]      data_q, data_n;
  logic [ERR_W-1:0]   err_q, err_n;
  logic               two_q, two_n;
  logic               ovr_q, ovr_n;
  logic               irq_q, irq_n;

  logic               start, start_we, acc_done;
  logic [RADDR_W-1:0] start_addr;
  logic [DW-1:0]      flag_word;
  logic               ready;

  assign flag_word = {{(DW-2){1'b0}}, ovr_q, irq_q};
  assign ready     = (state_q == ST_RSTAT) || (state_q == ST_RDATA);

  always_comb begin
    st_n       = state_q;
    op_n       = op_q;
    addr_n     = addr_q;
    data_n     = data_q;
    err_n      = err_q;
    two_n      = two_q;
    ovr_n      = ovr_q;
    irq_n      = irq_q | irq_set;
    start      = 1'b0;
    start_we   = 1'b0;
    start_addr = addr_q;
    case (state_q)
      ST_IDLE: begin
        if (xfer_wr) begin
          op_n   = cmd_op;
          addr_n = cmd_addr;
          err_n  = dec_err;
          case (dec_kind)
            K_READ: begin
              start      = 1'b1;
              start_addr = cmd_addr;
              two_n      = 1'b1;
              st_n       = ST_ACCESS;
            end
            K_WRITE: begin
              two_n = 1'b0;
              st_n  = ST_WDATA;
            end
            K_LOCAL: begin
              two_n  = 1'b1;
              data_n = dec_flags ? flag_word : '0;
              if (dec_irqclr)
                irq_n = irq_set;
              st_n   = ST_RSTAT;
            end
            default: begin
              two_n  = 1'b0;
              data_n = '0;
              st_n   = ST_RSTAT;
            end
          endcase
        end
      end
      ST_WDATA: begin
        if (xfer_wr) begin
          start    = 1'b1;
          start_we = 1'b1;
          st_n     = ST_ACCESS;
        end
      end
      ST_ACCESS: begin
        if (xfer_wr)
          ovr_n = 1'b1;
        if (acc_done) begin
          if (two_q)
            data_n = reg_rdata;
          st_n = ST_RSTAT;
        end
      end
      ST_RSTAT: begin
        if (xfer_wr) begin
          ovr_n = 1'b1;
        end else if (xfer_rd) begin
          ovr_n = 1'b0;
          st_n  = two_q ? ST_RDATA : ST_IDLE;
        end
      end
      ST_RDATA: begin
        if (xfer_wr)
          ovr_n = 1'b1;
        else if (xfer_rd)
          st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      err_q   <= '0;
      two_q   <= 1'b0;
      ovr_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= st_n;
      op_q    <= op_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
      err_q   <= err_n;
      two_q   <= two_n;
      ovr_q   <= ovr_n;
      irq_q   <= irq_n;
    end
  end

  rbb_reg_port #(
    .AW(RADDR_W),
    .DW(DW)
  ) u_port (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .start      (start),
    .start_we   (start_we),
    .start_addr (start_addr),
    .start_wdata(host_wdata),
    .done       (acc_done),
    .reg_req    (reg_req),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_ack    (reg_ack)
  );

  logic [DW-1:0] status_word;
  assign status_word = {op_q, {PAD_W{1'b0}}, ovr_q, err_q};

  rbb_resp_mux #(
    .DW(DW)
  ) u_mux (
    .sel_xfer   (xfer_rd),
    .sel_ready  (ready_rd),
    .ready      (ready),
    .show_status(state_q == ST_RSTAT),
    .show_data  (state_q == ST_RDATA),
    .status_word(status_word),
    .data_word  (data_q),
    .rdata      (host_rdata)
  );

endmodule

// File: rtl/rbb_bridge_chk.sv
module rbb_bridge_chk
  import rbb_pkg::*;
#(
  parameter int RADDR_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input st_e                state_q,
  input logic               ready,
  input logic               two_q,
  input logic               ovr_q,
  input logic               xfer_wr,
  input logic               xfer_rd,
  input logic [31:0]        host_wdata,
  input logic               reg_req,
  input logic               reg_ack,
  input logic               reg_we,
  input logic [RADDR_W-1:0] reg_addr,
  input logic [31:0]        reg_wdata
);

  logic legal_op;
  always_comb begin
    case (host_wdata[31:24])
      OPC_RD, OPC_SYSRD, OPC_WR, OPC_SYSWR, OPC_IRQCLR, OPC_FLAGS: legal_op = 1'b1;
      default: legal_op = 1'b0;
    endcase
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata))); // R6

  AST_NOT_READY_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> !ready); // R5

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && xfer_rd && ((state_q == ST_RDATA) || !two_q)) |=> !ready); // R10

  AST_LATE_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_wr && (state_q inside {ST_ACCESS, ST_RSTAT, ST_RDATA})) |=> ovr_q); // R9

  AST_BAD_OPCODE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && xfer_wr && !legal_op) |=> (ready && !reg_req)); // R7

endmodule

bind rbb_bridge rbb_bridge_chk #(.RADDR_W(RADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .state_q   (state_q),
  .ready     (ready),
  .two_q     (two_q),
  .ovr_q     (ovr_q),
  .xfer_wr   (xfer_wr),
  .xfer_rd   (xfer_rd),
  .host_wdata(host_wdata),
  .reg_req   (reg_req),
  .reg_ack   (reg_ack),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata)
);

// File: tb/sim_rbb_bridge.sv
`timescale 1ns/1ps
module sim_rbb_bridge;

  localparam logic [11:0] XO = 12'h600;
  localparam logic [11:0] RO = 12'h060;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] host_addr;
  logic        host_we, host_re;
  logic [31:0] host_wdata, host_rdata;
  logic        irq_set;
  logic        reg_req, reg_we, reg_ack;
  logic [23:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  always #2 clk = ~clk;

  rbb_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_we(host_we), .host_re(host_re),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_set(irq_set),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata)
  );

  // register space model, three-cycle acknowledge
  logic [31:0] rf [16];
  logic [1:0]  lat;
  int          acc_cnt;
  logic        last_we;
  logic [23:0] last_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_ack <= 1'b0;
      lat     <= 2'd0;
      acc_cnt <= 0;
      last_we <= 1'b0;
      last_addr <= '0;
      for (int i = 0; i < 16; i++) rf[i] <= 32'hA500_0000 + i;
    end else begin
      reg_ack <= 1'b0;
      if (reg_req && !reg_ack) begin
        if (lat == 2'd2) begin
          reg_ack   <= 1'b1;
          lat       <= 2'd0;
          acc_cnt   <= acc_cnt + 1;
          last_we   <= reg_we;
          last_addr <= reg_addr;
          if (reg_we) rf[reg_addr[3:0]] <= reg_wdata;
        end else begin
          lat <= lat + 2'd1;
        end
      end
    end
  end
  assign reg_rdata = rf[reg_addr[3:0]];

  logic [31:0] shadow [16];
  int n_chk = 0;
  int n_fail = 0;
  logic mon_en = 1'b0;
  logic [31:0] q_exp [$];
  string       q_tag [$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkst(input logic [7:0] op, input bit ovr, input logic [7:0] err);
    return {op, 15'b0, ovr, err};
  endfunction

  task automatic push(input logic [31:0] e, input string tag);
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  // monitor: compares every marked exchange read against the scoreboard
  always @(negedge clk) begin
    #1;
    if (host_re && mon_en && host_addr == XO) begin
      if (q_exp.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard empty actual=%h expected=none", host_rdata);
      end else begin
        chk(q_tag.pop_front(), host_rdata, q_exp.pop_front());
      end
    end
  end

  task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_we = 1'b1; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [11:0] a, input bit mon, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_re = 1'b1; mon_en = mon;
    #1 d = host_rdata;
    @(negedge clk);
    host_re = 1'b0; mon_en = 1'b0;
  endtask

  task automatic wait_ready(input string tag);
    logic [31:0] d;
    d = '0;
    for (int i = 0; i < 40; i++) begin
      hread(RO, 1'b0, d);
      if (d[0]) break;
    end
    chk(tag, {31'b0, d[0]}, 32'h1);
  endtask

  task automatic do_read(input logic [7:0] op, input logic [3:0] a, input bit ovr, input string tag);
    logic [31:0] d;
    hwrite(XO, {op, 20'h0, a});
    wait_ready(tag);
    push(mkst(op, ovr, 8'h00), tag);
    push(shadow[a], tag);
    hread(XO, 1'b1, d);
    hread(XO, 1'b1, d);
  endtask

  initial begin
    logic [31:0] d;
    int base, k;
    for (int i = 0; i < 16; i++) shadow[i] = 32'hA500_0000 + i;
    host_addr = '0; host_we = 1'b0; host_re = 1'b0; host_wdata = '0; irq_set = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 / R2 / R12: reset state and idle reads
    chk("R1 reg_req after reset", {31'b0, reg_req}, 32'h0);
    hread(RO, 1'b0, d); chk("R2 ready location after reset", d, 32'h0);
    hread(XO, 1'b0, d); chk("R12 idle exchange read", d, 32'h0);
    hread(RO, 1'b0, d); chk("R1 idle read left ready low", d, 32'h0);

    // R3 / R5 / R10: plain read
    hwrite(XO, {OPC(8'h01), 24'h000005});
    hread(RO, 1'b0, d); chk("R5 ready low during access", d, 32'h0);
    wait_ready("R3 ready raised");
    chk("R3 access direction", {31'b0, last_we}, 32'h0);
    chk("R3 access address", {8'b0, last_addr}, 32'h5);
    push(mkst(8'h01, 1'b0, 8'h00), "R3 status word");
    push(shadow[5], "R3 read data");
    hread(XO, 1'b1, d);
    hread(XO, 1'b1, d);
    hread(RO, 1'b0, d); chk("R10 ready cleared after data", d, 32'h0);

    // R4 / R12: system write, then readback by system read
    hwrite(XO, {8'h20, 24'h000003});
    hread(XO, 1'b0, d); chk("R12 read while awaiting write data", d, 32'h0);
    hwrite(XO, 32'hDEAD_BEEF);
    hread(RO, 1'b0, d); chk("R5 ready low during write access", d, 32'h0);
    shadow[3] = 32'hDEAD_BEEF;
    wait_ready("R4 ready raised");
    chk("R4 access direction", {31'b0, last_we}, 32'h1);
    chk("R4 access address", {8'b0, last_addr}, 32'h3);
    push(mkst(8'h20, 1'b0, 8'h00), "R4 status word");
    hread(XO, 1'b1, d);
    hread(RO, 1'b0, d); chk("R4 single response word", d, 32'h0);
    do_read(8'h02, 4'h3, 1'b0, "R4 written value read back");

    // R7: null and undefined opcodes
    base = acc_cnt;
    hwrite(XO, {8'h00, 24'h000001});
    wait_ready("R7 null completes");
    push(mkst(8'h00, 1'b0, 8'h01), "R7 null error code");
    hread(XO, 1'b1, d);
    hread(RO, 1'b0, d); chk("R7 null single word", d, 32'h0);
    hwrite(XO, {8'h33, 24'h000002});
    wait_ready("R7 undefined completes");
    push(mkst(8'h33, 1'b0, 8'h02), "R7 undefined error code");
    hread(XO, 1'b1, d);
    hread(RO, 1'b0, d); chk("R7 undefined single word", d, 32'h0);
    chk("R7 no register access", acc_cnt - base, 32'h0);

    // R8 / R11: flag query and interrupt clear
    @(negedge clk); irq_set = 1'b1;
    @(negedge clk); irq_set = 1'b0;
    hwrite(XO, {8'h80, 24'h0});
    wait_ready("R8 flag query ready");
    push(mkst(8'h80, 1'b0, 8'h00), "R8 flag query status");
    push(32'h1, "R11 pending interrupt visible");
    hread(XO, 1'b1, d); hread(XO, 1'b1, d);
    hwrite(XO, {8'h40, 24'h0});
    wait_ready("R8 irq clear ready");
    push(mkst(8'h40, 1'b0, 8'h00), "R8 irq clear status");
    push(32'h0, "R8 irq clear data");
    hread(XO, 1'b1, d); hread(XO, 1'b1, d);
    hwrite(XO, {8'h80, 24'h0});
    wait_ready("R8 second flag query ready");
    push(mkst(8'h80, 1'b0, 8'h00), "R8 second flag status");
    push(32'h0, "R8 interrupt flag cleared");
    hread(XO, 1'b1, d); hread(XO, 1'b1, d);

    // R9: late write during the access
    base = acc_cnt;
    hwrite(XO, {8'h01, 24'h000007});
    hwrite(XO, {8'h10, 24'h000009});
    wait_ready("R9 ready after in-flight write");
    push(mkst(8'h01, 1'b1, 8'h00), "R9 overrun in status word");
    push(shadow[7], "R9 data unaffected");
    hread(XO, 1'b1, d); hread(XO, 1'b1, d);
    chk("R9 ignored write caused no access", acc_cnt - base, 32'h1);
    do_read(8'h01, 4'h7, 1'b0, "R9 overrun cleared after report");

    // R9: late write while read data is pending
    hwrite(XO, {8'h01, 24'h000004});
    wait_ready("R9 ready second case");
    push(mkst(8'h01, 1'b0, 8'h00), "R9 status before late write");
    hread(XO, 1'b1, d);
    base = acc_cnt;
    hwrite(XO, {8'h20, 24'h000004});
    hread(RO, 1'b0, d); chk("R9 ready kept after ignored write", d, 32'h1);
    push(shadow[4], "R9 pending data intact");
    hread(XO, 1'b1, d);
    hread(RO, 1'b0, d); chk("R9 no new transaction started", d, 32'h0);
    chk("R9 no access from ignored write", acc_cnt - base, 32'h0);
    do_read(8'h01, 4'h4, 1'b1, "R9 overrun reported in next status");

    // R10: drain loop retires exactly the pending word
    hwrite(XO, {8'h01, 24'h000002});
    wait_ready("R10 drain setup");
    push(mkst(8'h01, 1'b0, 8'h00), "R10 status before drain");
    hread(XO, 1'b1, d);
    k = 0;
    for (int i = 0; i < 8; i++) begin
      hread(RO, 1'b0, d);
      if (!d[0]) break;
      hread(XO, 1'b0, d);
      k++;
    end
    chk("R10 drain reads consumed", k, 32'h1);
    hread(RO, 1'b0, d); chk("R10 ready low after drain", d, 32'h0);

    repeat (4) @(negedge clk);
    chk("scoreboard drained", q_exp.size(), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  function automatic logic [7:0] OPC(input logic [7:0] v);
    return v;
  endfunction

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule